// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-attached watchdog. The input clock passes through two divider stages before it reaches a 16-bit down-counter. The first stage is a programmable 8-bit prescaler. The second stage is a fixed power-of-two divider chosen by a 2-bit field. Software keeps the system alive by writing a fresh value straight into the live counter before it runs out.

When a tick arrives while the counter holds zero, the counter expires. On expiry the counter reloads from a separate reload register. It can also latch a level interrupt, start a fixed-length system reset pulse, or do both; each action has its own enable bit. A pending interrupt stays high until software writes 1 to a dedicated clear location.

The register bus uses 32-bit words, a byte address, a write strobe and write data. Read data is registered and appears one clock after the address.

Top module: `dog_timer`

## Requirements
- R1: After reset, control reads 0x00008021 (prescale 0x80, divide 16, timer running, reset action on). Reload and counter both read 0x00008000. The interrupt and reset outputs are low.
- R2: The word offsets are 0x0 control, 0x4 reload, 0x8 counter and 0xC interrupt clear. Read data appears one clock after the address. The clear offset reads zero. The control word uses these bits, and all other bits read 0:
  - [15:8] prescale value P
  - [5] run
  - [4:3] divide select
  - [2] interrupt enable
  - [0] reset enable
- R3: While running, ticks come every (P+1)·F input clocks. The divide select picks F: code 0 gives 16, code 1 gives 32, code 2 gives 64, code 3 gives 128.
- R4: A tick that finds the counter at zero is an expiry, and the counter reloads from the reload register. With reload value D, expiries repeat every (D+1) ticks.
- R5: An expiry sets the interrupt output only when the interrupt enable bit is 1. The output then stays high until it is cleared.
- R6: Writing a word with bit 0 set to the clear offset drops the pending interrupt on the next clock. An expiry in that same clock keeps it set.
- R7: An expiry starts the reset output only when the reset enable bit is 1. The pulse lasts exactly 128 clocks, and an expiry during a pulse does not stretch it.
- R8: A write to the counter offset loads its low 16 bits on the next clock. This load wins over a tick in the same clock, so writing regularly prevents any expiry.
- R9: With run at 0, the counter holds its value and both divider stages sit at zero. A later start therefore reaches its first tick exactly (P+1)·F clocks after the enabling write takes effect.
- R10: Writing the reload register does not change the live counter. The new value is used only at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the divider source |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| irq_o | output | 1 | Level interrupt, pending expiry |
| wd_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with its default parameters: 16-bit counter, base divide of 16 and a 128-clock reset pulse. It programs prescale values of 0 to 2 and reload values of 0 to 5. This brings every divide code within a few hundred clocks, along with the exact distance between expiries and the exact length of the first tick after a restart. A reset pulse that overlaps several expiries, and keepalive writes racing the tick, are also reached in short runs.

// File: rtl/dog_pkg.sv
package dog_pkg;
  localparam int PRE_W = 8;
  localparam int SEL_W = 2;

  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_RELOAD = 2'd1;
  localparam logic [1:0] IDX_COUNT  = 2'd2;
  localparam logic [1:0] IDX_CLEAR  = 2'd3;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             run;
    logic [SEL_W-1:0] div_sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
    ctrl_t c;
    c.pre     = w[15:8];
    c.run     = w[5];
    c.div_sel = w[4:3];
    c.irq_en  = w[2];
    c.rst_en  = w[0];
    return c;
  endfunction

  function automatic logic [15:0] ctrl_to_word(input ctrl_t c);
    return {c.pre, 2'b00, c.run, c.div_sel, c.irq_en, 1'b0, c.rst_en};
  endfunction
endpackage

// File: rtl/dog_regs.sv
module dog_regs
  import dog_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [15:0] CTRL_RST = 16'h8021,
  parameter logic [CNT_W-1:0] DATA_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              clr_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_LSB = 2;

  logic [1:0] widx;
  logic       unused_bits;

  assign widx        = addr[IDX_LSB +: 2];
  assign unused_bits = ^{addr, wdata};
  assign cnt_wr      = we && (widx == IDX_COUNT);
  assign cnt_wdata   = wdata[CNT_W-1:0];
  assign clr_wr      = we && (widx == IDX_CLEAR) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= ctrl_from_word(CTRL_RST);
      reload <= DATA_RST;
    end else if (we) begin
      if (widx == IDX_CTRL)   ctrl   <= ctrl_from_word(wdata[15:0]);
      if (widx == IDX_RELOAD) reload <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (widx)
        IDX_CTRL:   rdata <= DATA_W'(ctrl_to_word(ctrl));
        IDX_RELOAD: rdata <= DATA_W'(reload);
        IDX_COUNT:  rdata <= DATA_W'(cnt_val);
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dog_divider.sv
module dog_divider
  import dog_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int S2_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [S2_W-1:0]  s2_q;
  logic [S2_W:0]    s2_span;
  logic [S2_W-1:0]  s2_last;

  assign s2_span = (S2_W+1)'(1) << (BASE_LOG2 + 32'(sel));
  assign s2_last = S2_W'(s2_span - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      s2_q  <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_q >= pre) begin
        pre_q <= '0;
        if (s2_q >= s2_last) begin
          s2_q <= '0;
          tick <= 1'b1;
        end else begin
          s2_q <= s2_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dog_counter.sv
module dog_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  assign expire = run && tick && !ld && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_RST;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (run && tick) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dog_pulse.sv
module dog_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (!pulse) begin
      if (start) begin
        pulse <= 1'b1;
        left  <= W'(LEN - 1);
      end
    end else if (left == '0) begin
      pulse <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/dog_timer.sv
module dog_timer
  import dog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BASE_LOG2 = 4,
  parameter int RST_LEN   = 128,
  parameter logic [15:0]      CTRL_RST = 16'h8021,
  parameter logic [CNT_W-1:0] DATA_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wd_rst_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_wdata;
  logic             cnt_wr;
  logic             clr_wr;
  logic             tick;
  logic             expire;
  logic             run;
  logic             irq_en;
  logic             rst_en;

  assign run    = ctrl.run;
  assign irq_en = ctrl.irq_en;
  assign rst_en = ctrl.rst_en;

  dog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_RST(CTRL_RST), .DATA_RST(DATA_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cnt_val(cnt_q), .ctrl(ctrl), .reload(reload), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .clr_wr(clr_wr), .rdata(bus_rdata)
  );

  dog_divider #(.BASE_LOG2(BASE_LOG2)) u_div (
    .clk(clk), .rst(rst), .run(run), .pre(ctrl.pre), .sel(ctrl.div_sel),
    .tick(tick)
  );

  dog_counter #(.CNT_W(CNT_W), .CNT_RST(DATA_RST)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .ld(cnt_wr),
    .ld_val(cnt_wdata), .reload(reload), .cnt_q(cnt_q), .expire(expire)
  );

  dog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(expire && rst_en), .pulse(wd_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                    irq_o <= 1'b0;
    else if (expire && irq_en)  irq_o <= 1'b1;
    else if (clr_wr)            irq_o <= 1'b0;
  end
endmodule

// File: rtl/dog_timer_chk.sv
module dog_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             wd_rst_o,
  input logic             run,
  input logic             irq_en,
  input logic             rst_en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             clr_wr,
  input logic             expire
);
  localparam int HW = $clog2(RST_LEN + 2) + 1;

  logic [HW-1:0] hi;

  always_ff @(posedge clk) begin
    if (rst || !wd_rst_o)             hi <= '0;
    else if (hi != {HW{1'b1}})        hi <= hi + 1'b1;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(irq_en)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_wr) |=> irq_o); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !expire) |=> !irq_o); // R6
  AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_o) |-> $past(rst_en)); // R7
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_rst_o) |-> (32'(hi) == RST_LEN)); // R7
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |-> (32'(hi) < RST_LEN)); // R7
  AST_KEEPALIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wdata))); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt_q)); // R9
endmodule

bind dog_timer dog_timer_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .wd_rst_o(wd_rst_o), .run(run),
  .irq_en(irq_en), .rst_en(rst_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cnt_q(cnt_q), .clr_wr(clr_wr), .expire(expire)
);

// File: tb/test_dog_timer.sv
module test_dog_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        wd_rst_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dog_timer i_dog_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .wd_rst_o(wd_rst_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int pre, input int sel, input bit run,
                                          input bit ie, input bit re);
    return {16'h0, 8'(pre), 2'b00, run, 2'(sel), ie, 1'b0, re};
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk); #1;
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!irq_o && n < limit);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    check(wd_rst_o == 1'b0, "R1 reset out after reset", wd_rst_o, 0);
    bus_read(4'h0, d); check(d == 32'h8021, "R1 ctrl reset value", d, 32'h8021);
    bus_read(4'h4, d); check(d == 32'h8000, "R1 reload reset value", d, 32'h8000);
    bus_read(4'h8, d); check(d == 32'h8000, "R1 counter reset value", d, 32'h8000);
    bus_read(4'hC, d); check(d == 32'h0, "R2 clear offset reads zero", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, d); check(d == 32'hFF3D, "R2 ctrl unused bits zero", d, 32'hFF3D);
    bus_write(4'h0, 32'h0);
    bus_write(4'h8, 32'hABCD_1234);
    bus_read(4'h8, d); check(d == 32'h1234, "R8 counter write loads", d, 32'h1234);
    bus_write(4'h4, 32'h0077);
    bus_read(4'h4, d); check(d == 32'h0077, "R2 reload readback", d, 32'h77);
    bus_read(4'h8, d); check(d == 32'h1234, "R10 reload leaves counter", d, 32'h1234);
    repeat (60) @(posedge clk);
    #1;
    bus_read(4'h8, d); check(d == 32'h1234, "R9 counter frozen when stopped", d, 32'h1234);
  endtask

  task automatic t_first_tick();
    int n;
    logic [31:0] d;
    bus_write(4'h0, 32'h0);
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, mk_ctrl(1, 1, 1, 1, 0));
    wait_irq(1000, n);
    check(n == 65, "R9 first tick after start, clocks", n, 65);
    check(wd_rst_o == 1'b0, "R7 no reset pulse when reset enable is 0", wd_rst_o, 0);
    bus_write(4'h0, 32'h0);
    bus_read(4'h8, d); check(d == 32'h0077, "R4 counter reloaded on expiry", d, 32'h77);
    check(irq_o == 1'b1, "R5 interrupt held while pending", irq_o, 1);
    bus_write(4'hC, 32'h0);
    check(irq_o == 1'b1, "R6 clear write with bit0 low keeps irq", irq_o, 1);
    bus_write(4'hC, 32'h1);
    check(irq_o == 1'b0, "R6 clear write drops irq", irq_o, 0);
  endtask

  task automatic t_interval(input int pre, input int sel, input int rl,
                            input int exp, input string req);
    int n;
    bus_write(4'h0, 32'h0);
    bus_write(4'hC, 32'h1);
    bus_write(4'h4, 32'(rl));
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, mk_ctrl(pre, sel, 1, 1, 0));
    wait_irq(5000, n);
    bus_write(4'hC, 32'h1);
    wait_irq(5000, n);
    check(n + 1 == exp, req, n + 1, exp);
    bus_write(4'h0, 32'h0);
    bus_write(4'hC, 32'h1);
  endtask

  task automatic t_pulse();
    int n;
    int w;
    bus_write(4'h0, 32'h0);
    bus_write(4'h4, 32'h0);
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, mk_ctrl(0, 0, 1, 0, 1));
    n = 0;
    while (!wd_rst_o && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
    check(wd_rst_o == 1'b1, "R7 reset pulse starts", wd_rst_o, 1);
    w = 0;
    while (wd_rst_o && w < 1000) begin
      @(posedge clk); #1;
      w++;
    end
    check(w == 128, "R7 pulse width despite repeated expiries", w, 128);
    check(irq_o == 1'b0, "R5 no irq when interrupt enable is 0", irq_o, 0);
    bus_write(4'h0, 32'h0);
    repeat (200) @(posedge clk);
    #1;
    check(wd_rst_o == 1'b0, "R7 pulse ends after stop", wd_rst_o, 0);
  endtask

  task automatic t_keepalive();
    int n;
    bit seen = 1'b0;
    bus_write(4'h0, 32'h0);
    bus_write(4'hC, 32'h1);
    bus_write(4'h4, 32'h5);
    bus_write(4'h8, 32'h5);
    bus_write(4'h0, mk_ctrl(0, 0, 1, 1, 0));
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1;
        if (irq_o) seen = 1'b1;
      end
      bus_write(4'h8, 32'h5);
    end
    check(!seen, "R8 keepalive writes prevent expiry", seen, 0);
    wait_irq(500, n);
    check(irq_o == 1'b1, "R8 expiry once keepalive stops", irq_o, 1);
    bus_write(4'h0, 32'h0);
    bus_write(4'hC, 32'h1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_regs();
    t_first_tick();
    t_interval(0, 0, 2, 48,  "R4 expiry interval reload 2 divide 16");
    t_interval(0, 2, 0, 64,  "R3 tick period divide code 2");
    t_interval(2, 3, 0, 384, "R3 tick period prescale 2 divide code 3");
    t_interval(1, 0, 1, 64,  "R3 tick period prescale 1 divide code 0");
    t_pulse();
    t_keepalive();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule